// File: doc/BRIEF.md
# Serial EEPROM Command Engine

This block is the command side of a byte-wide serial nonvolatile memory that answers as a slave on a Mode 0 SPI bus. Chip select, serial clock and serial data in are brought through synchronisers into a faster system clock. A one-byte opcode picks one of six commands: latch set, latch clear, status read, status write, array read and array write. Serial data out comes with a separate enable, so the pad can float the line when the block is not talking.

Array writes collect up to one page in a buffer. They become permanent only when chip select is released cleanly at a byte boundary. A self-timed busy interval then follows, and its length in system clocks is set by a parameter. Whether a write may go ahead is decided outside the block by a protection checker. The engine shows that checker the page being written, whether the pending write targets the status register, and the current protection fields. It then samples the checker's grant on the cycle it sees chip select rise. The array is a register file of 2^ADDR_W bytes. The default is kept small for simulation, and ADDR_W = 14 gives a 16,384-byte array.

Top module: `spi_eeprom_engine`

## Requirements
- R1: An opcode byte is accepted only when its upper four bits are 0. Bit 3 is ignored. Bits 2..0 select the command: 110 sets the write-enable latch, 100 clears it, 101 reads status, 001 writes status, 011 reads the array and 010 writes the array.
- R2: The write-enable latch is 0 after reset. The set and clear commands change it, and it is seen as status bit 1.
- R3: Any other opcode (upper nibble nonzero, or low bits 000 or 111) leaves `so_oe` low and changes no state for the rest of that selection. Normal decoding resumes after the next falling edge of `cs_n`.
- R4: A read takes a 16-bit address, sent MSB first, whose bits above ADDR_W are ignored. Data bytes then stream out MSB first, with the address incrementing after each byte and wrapping from the top location to 0.
- R5: During an array write, only the low 6 address bits advance after each data byte. More than 64 bytes therefore wrap inside the page, and the later bytes overwrite earlier ones.
- R6: A write, whether to the array or to status, is committed only if `cs_n` rises at a byte boundary after at least one full data byte, with the latch set and `wr_grant` high. Otherwise nothing is written and the latch keeps its value.
- R7: A committed write holds the block busy for WR_CLKS system clocks. During that time the status read returns 0xFF and every other command is ignored. The latch clears when busy ends.
- R8: Status is formatted as follows when idle: bit 0 is busy, bit 1 is the latch, bits 3:2 are the protection level and bit 7 is the protection enable; all other bits are 0. A status write loads bits 7, 3 and 2 from its data byte. `prot_lvl` and `prot_en` show the stored fields.
- R9: During an array write, `wr_addr` shows the page base (low 6 bits 0) and `wr_stat` is low. After a status data byte, `wr_stat` is high.
- R10: After reset every array byte reads 0xFF. `so_oe` is high only while the block is selected and serving a read or status read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock, Mode 0 |
| si | input | 1 | Serial data in |
| wr_grant | input | 1 | Write permission from the protection checker |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Output enable for `so` |
| wr_addr | output | ADDR_W | Page base of the pending array write |
| wr_stat | output | 1 | Pending write targets the status register |
| prot_lvl | output | 2 | Stored block protection level |
| prot_en | output | 1 | Stored protection enable |

## Verification
The assertions assume that `sck` and `cs_n` change slowly enough for each edge to pass the synchronisers before the next one arrives. They also assume that `cs_n` never moves in the same few clocks as `sck`, and that `si` is stable around each rising `sck`. The bench holds every serial half-period for six system clocks, changes `si` only with falling `sck`, and moves `cs_n` only while `sck` is low and after a settle time. Random addresses, lengths, latch states and grant values are drawn within those rules. Directed cases cover page wrap, array rollover, aborts in the middle of a byte, invalid opcodes and commands sent while busy.

// File: rtl/spi_eeprom_engine.sv
module spi_eeprom_engine #(
  parameter int ADDR_W  = 10,
  parameter int PAGE_W  = 6,
  parameter int WR_CLKS = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  input  logic              wr_grant,
  output logic              so,
  output logic              so_oe,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              wr_stat,
  output logic [1:0]        prot_lvl,
  output logic              prot_en
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int CNT_W = $clog2(WR_CLKS + 1);

  typedef enum logic [2:0] {
    PH_OP, PH_AH, PH_AL, PH_RD, PH_WD, PH_SRD, PH_SWR, PH_IGN
  } phase_t;

  logic [2:0] cs_q, sck_q;
  logic [1:0] si_q;
  logic       cs_s, cs_rise, cs_fall, sck_rise, sck_fall;

  phase_t            phase;
  logic [2:0]        bitc;
  logic [6:0]        shr;
  logic              cmd_wr;
  logic [ADDR_W-9:0] ahi;
  logic [ADDR_W-1:0] addr;
  logic [PG_W-1:0]   page;
  logic [PAGE_W-1:0] wptr;
  logic [7:0]        pbuf [PAGE];
  logic [PAGE-1:0]   pflag;
  logic              have_data, s_pend;
  logic [2:0]        sval;
  logic [7:0]        osh;
  logic              oe_r, busy, wel, pen;
  logic [1:0]        bp;
  logic [CNT_W-1:0]  bcnt;
  logic [7:0]        mem [DEPTH];

  logic [7:0]        byte_in, stat;
  logic [ADDR_W-1:0] a_full;

  assign cs_s     = cs_q[1];
  assign cs_rise  = cs_q[1] & ~cs_q[2];
  assign cs_fall  = ~cs_q[1] & cs_q[2];
  assign sck_rise = sck_q[1] & ~sck_q[2];
  assign sck_fall = ~sck_q[1] & sck_q[2];
  assign byte_in  = {shr, si_q[1]};
  assign a_full   = {ahi, byte_in};
  assign stat     = busy ? 8'hFF : {pen, 3'b000, bp, wel, 1'b0};

  assign so       = osh[7];
  assign so_oe    = oe_r;
  assign wr_addr  = {page, PAGE_W'(0)};
  assign wr_stat  = (phase == PH_SWR) && s_pend;
  assign prot_lvl = bp;
  assign prot_en  = pen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_q  <= 3'b111;
      sck_q <= 3'b000;
      si_q  <= 2'b00;
    end else begin
      cs_q  <= {cs_q[1:0], cs_n};
      sck_q <= {sck_q[1:0], sck};
      si_q  <= {si_q[0], si};
    end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IGN; bitc <= '0; shr <= '0; cmd_wr <= 1'b0;
      ahi <= '0; addr <= '0; page <= '0; wptr <= '0;
      pflag <= '0; have_data <= 1'b0; s_pend <= 1'b0; sval <= '0;
      osh <= '0; oe_r <= 1'b0; busy <= 1'b0; wel <= 1'b0;
      pen <= 1'b0; bp <= '0; bcnt <= '0;
      for (int i = 0; i < PAGE; i++) pbuf[i] <= 8'h00;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
    end else begin
      if (busy) begin
        if (bcnt == '0) begin
          busy <= 1'b0;
          wel  <= 1'b0;
        end else bcnt <= bcnt - CNT_W'(1);
      end

      if (cs_fall) begin
        phase <= PH_OP; bitc <= '0; oe_r <= 1'b0;
        pflag <= '0; have_data <= 1'b0; s_pend <= 1'b0;
      end else if (cs_s) begin
        oe_r <= 1'b0;
        if (cs_rise && bitc == 3'd0 && wel && wr_grant) begin
          if (phase == PH_WD && have_data) begin
            for (int i = 0; i < PAGE; i++)
              if (pflag[i]) mem[{page, PAGE_W'(i)}] <= pbuf[i];
            busy <= 1'b1;
            bcnt <= CNT_W'(WR_CLKS - 1);
          end else if (phase == PH_SWR && s_pend) begin
            pen  <= sval[2];
            bp   <= sval[1:0];
            busy <= 1'b1;
            bcnt <= CNT_W'(WR_CLKS - 1);
          end
        end
      end else if (sck_rise && phase != PH_IGN) begin
        shr  <= byte_in[6:0];
        bitc <= bitc + 3'd1;
        if (bitc == 3'd7) begin
          unique case (phase)
            PH_OP: begin
              if (byte_in[7:4] != 4'h0 || (busy && byte_in[2:0] != 3'b101))
                phase <= PH_IGN;
              else begin
                unique case (byte_in[2:0])
                  3'b110: begin wel <= 1'b1; phase <= PH_IGN; end
                  3'b100: begin wel <= 1'b0; phase <= PH_IGN; end
                  3'b101: phase <= PH_SRD;
                  3'b001: phase <= PH_SWR;
                  3'b011: begin cmd_wr <= 1'b0; phase <= PH_AH; end
                  3'b010: begin cmd_wr <= 1'b1; phase <= PH_AH; end
                  default: phase <= PH_IGN;
                endcase
              end
            end
            PH_AH: begin
              ahi   <= byte_in[ADDR_W-9:0];
              phase <= PH_AL;
            end
            PH_AL: begin
              if (cmd_wr) begin
                page  <= a_full[ADDR_W-1:PAGE_W];
                wptr  <= a_full[PAGE_W-1:0];
                phase <= PH_WD;
              end else begin
                addr  <= a_full;
                phase <= PH_RD;
              end
            end
            PH_WD: begin
              pbuf[wptr]  <= byte_in;
              pflag[wptr] <= 1'b1;
              wptr        <= wptr + PAGE_W'(1);
              have_data   <= 1'b1;
            end
            PH_SWR: begin
              sval   <= {byte_in[7], byte_in[3:2]};
              s_pend <= 1'b1;
            end
            default: ;
          endcase
        end
      end else if (sck_fall && (phase == PH_RD || phase == PH_SRD)) begin
        if (bitc == 3'd0) begin
          oe_r <= 1'b1;
          if (phase == PH_RD) begin
            osh  <= mem[addr];
            addr <= addr + ADDR_W'(1);
          end else osh <= stat;
        end else osh <= {osh[6:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/spi_eeprom_engine_chk.sv
module spi_eeprom_engine_chk #(
  parameter int WR_CLKS = 40
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       wel,
  input logic       so_oe,
  input logic [2:0] phase
);
  int blen;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) blen <= 0;
    else        blen <= busy ? blen + 1 : 0;

  a_r7_busy_len: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (blen == WR_CLKS));

  a_r7_latch_drop: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> !wel);

  a_r6_needs_latch: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wel));

  a_r3_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == 3'd7) |-> !so_oe);

  a_r10_oe_read_only: assert property (@(posedge clk) disable iff (!rst_n)
    so_oe |-> (phase == 3'd3 || phase == 3'd5));
endmodule

bind spi_eeprom_engine spi_eeprom_engine_chk #(.WR_CLKS(WR_CLKS)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wel(wel), .so_oe(so_oe), .phase(phase)
);

// File: tb/test_spi_eeprom_engine.sv
module test_spi_eeprom_engine;
  localparam int AW   = 10;
  localparam int WRC  = 1500;
  localparam int HALF = 6;

  logic clk = 0, rst_n = 0, cs_n = 1, sck = 0, si = 0, wr_grant = 1;
  logic so, so_oe, wr_stat, prot_en;
  logic [AW-1:0] wr_addr;
  logic [1:0] prot_lvl;

  spi_eeprom_engine #(.ADDR_W(AW), .PAGE_W(6), .WR_CLKS(WRC)) i_spi_eeprom_engine (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si), .wr_grant(wr_grant),
    .so(so), .so_oe(so_oe), .wr_addr(wr_addr), .wr_stat(wr_stat),
    .prot_lvl(prot_lvl), .prot_en(prot_en));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  logic [7:0] mem_m [1 << AW];
  logic wel_m = 0, pen_m = 0, committed = 0;
  logic [1:0] bp_m = 0;
  logic [7:0] wbuf [128];
  logic [7:0] rbuf [128];
  logic rd_oe;
  logic [AW-1:0] seen_addr;
  logic seen_stat;

  task automatic tick(input int n); repeat (n) @(negedge clk); endtask

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_stat();
    return {pen_m, 3'b000, bp_m, wel_m, 1'b0};
  endfunction

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic oe_any);
    oe_any = 0; rx = 0;
    for (int i = 7; i >= 0; i--) begin
      si = tx[i]; tick(HALF);
      rx[i] = so; if (so_oe) oe_any = 1;
      sck = 1; tick(HALF); sck = 0;
    end
  endtask

  task automatic xbits(input int n);
    for (int i = 0; i < n; i++) begin
      si = 1; tick(HALF); sck = 1; tick(HALF); sck = 0;
    end
  endtask

  task automatic cs_lo; cs_n = 0; tick(HALF); endtask
  task automatic cs_hi; tick(HALF); cs_n = 1; tick(10); endtask

  task automatic op1(input logic [7:0] op, input logic model_ok);
    logic [7:0] r; logic o;
    cs_lo; xbyte(op, r, o); cs_hi;
    if (model_ok && op[2:0] == 3'b110) wel_m = 1;
    if (model_ok && op[2:0] == 3'b100) wel_m = 0;
  endtask

  task automatic rdsr(output logic [7:0] v, output logic o);
    logic [7:0] r; logic o1;
    cs_lo; xbyte(8'h05, r, o1); xbyte(8'h00, v, o); cs_hi;
  endtask

  task automatic wait_ready;
    logic [7:0] v; logic o;
    for (int k = 0; k < 60; k++) begin
      rdsr(v, o);
      if (v[0] == 1'b0) break;
    end
  endtask

  task automatic do_read(input logic [7:0] op, input logic [15:0] a, input int n);
    logic [7:0] r; logic o;
    rd_oe = 0;
    cs_lo; xbyte(op, r, o); xbyte(a[15:8], r, o); xbyte(a[7:0], r, o);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, rbuf[k], o); if (o) rd_oe = 1;
    end
    cs_hi;
  endtask

  task automatic check_read(input string tag, input logic [15:0] a, input int n);
    do_read(8'h03, a, n);
    for (int k = 0; k < n; k++)
      check(tag, rbuf[k], mem_m[AW'(a[AW-1:0] + AW'(k))]);
  endtask

  task automatic do_write(input logic [15:0] a, input int n, input int extra, input logic g);
    logic [7:0] r; logic o;
    wr_grant = g; committed = 0;
    cs_lo; xbyte(8'h02, r, o); xbyte(a[15:8], r, o); xbyte(a[7:0], r, o);
    for (int k = 0; k < n; k++) xbyte(wbuf[k], r, o);
    if (extra > 0) xbits(extra);
    tick(1); seen_addr = wr_addr; seen_stat = wr_stat;
    cs_hi;
    if (wel_m && g && n > 0 && extra == 0) begin
      for (int k = 0; k < n; k++)
        mem_m[{a[AW-1:6], 6'(a[5:0] + 6'(k))}] = wbuf[k];
      wel_m = 0; committed = 1;
    end
  endtask

  task automatic do_wrsr(input logic [7:0] v, input logic g);
    logic [7:0] r; logic o;
    wr_grant = g; committed = 0;
    cs_lo; xbyte(8'h01, r, o); xbyte(v, r, o);
    tick(1); seen_stat = wr_stat;
    cs_hi;
    if (wel_m && g) begin
      pen_m = v[7]; bp_m = v[3:2]; wel_m = 0; committed = 1;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v; logic o;
    void'($urandom(32'h5EED1234));
    for (int i = 0; i < (1 << AW); i++) mem_m[i] = 8'hFF;
    tick(5); rst_n = 1; tick(5);

    check("R10 oe low after reset", so_oe, 0);
    rdsr(v, o);
    check("R2 status after reset", v, 8'h00);
    check("R10 oe during status read", o, 1);
    check_read("R10 reset contents", 16'h0123, 3);

    // R6: write without the latch is dropped
    for (int k = 0; k < 4; k++) wbuf[k] = 8'(k + 8'h40);
    do_write(16'h0010, 4, 0, 1);
    rdsr(v, o);
    check("R6 no latch no busy", v, exp_stat());
    check_read("R6 no latch data", 16'h0010, 4);

    // R1/R2: latch set and clear, bit 3 ignored
    op1(8'h06, 1); rdsr(v, o); check("R2 latch set", v, 8'h02);
    op1(8'h0C, 1); rdsr(v, o); check("R1 clear with bit3", v, 8'h00);
    op1(8'h0E, 1); rdsr(v, o); check("R1 set with bit3", v, 8'h02);
    op1(8'h04, 1); rdsr(v, o); check("R2 latch clear", v, 8'h00);

    // R3: invalid opcodes
    op1(8'h16, 0); rdsr(v, o); check("R3 bad nibble keeps latch", v, 8'h00);
    do_read(8'h43, 16'h0000, 2); check("R3 bad read silent", rd_oe, 0);
    do_read(8'h07, 16'h0000, 2); check("R3 code 111 silent", rd_oe, 0);
    rdsr(v, o); check("R3 next select normal", v, exp_stat());

    // R5/R7/R9: long page write that wraps
    for (int k = 0; k < 70; k++) wbuf[k] = 8'($urandom);
    op1(8'h06, 1);
    do_write(16'hF1B8, 70, 0, 1);
    check("R9 page base", seen_addr, 10'h180);
    check("R9 not status", seen_stat, 0);
    rdsr(v, o); check("R7 busy status", v, 8'hFF);
    do_read(8'h03, 16'h0180, 2); check("R7 read ignored while busy", rd_oe, 0);
    op1(8'h06, 0);
    wait_ready;
    rdsr(v, o); check("R7 latch cleared after cycle", v, 8'h00);
    check_read("R5 page wrap", 16'h0180, 64);
    check_read("R5 neighbour page", 16'h01C0, 2);

    // R4: rollover and ignored upper bits, bit 3 ignored
    for (int k = 0; k < 2; k++) wbuf[k] = 8'(8'hA0 + k);
    op1(8'h06, 1); do_write(16'h03FE, 2, 0, 1); wait_ready;
    do_read(8'h0B, 16'hC3FE, 4);
    check("R4 top-1", rbuf[0], mem_m[10'h3FE]);
    check("R4 top", rbuf[1], mem_m[10'h3FF]);
    check("R4 wrap 0", rbuf[2], mem_m[10'h000]);
    check("R4 wrap 1", rbuf[3], mem_m[10'h001]);

    // R6: mid-byte abort and missing data
    wbuf[0] = 8'h11;
    op1(8'h06, 1); do_write(16'h0200, 1, 3, 1);
    rdsr(v, o); check("R6 mid-byte abort keeps latch", v, 8'h02);
    do_write(16'h0200, 0, 0, 1);
    rdsr(v, o); check("R6 no data byte", v, 8'h02);
    do_write(16'h0200, 1, 0, 0);
    rdsr(v, o); check("R6 grant low", v, 8'h02);
    check_read("R6 aborted data", 16'h0200, 1);

    // R8/R9: status writes
    do_wrsr(8'h8C, 1);
    check("R9 status pending flag", seen_stat, 1);
    wait_ready;
    rdsr(v, o); check("R8 status written", v, exp_stat());
    check("R8 level pins", {prot_en, prot_lvl}, 3'b111);
    op1(8'h06, 1); do_wrsr(8'h04, 0);
    rdsr(v, o); check("R8 status write refused", v, exp_stat());
    do_wrsr(8'h74, 1); wait_ready;
    rdsr(v, o); check("R8 reserved bits zero", v, exp_stat());

    // random mix
    for (int it = 0; it < 24; it++) begin
      logic [15:0] a; int n; logic g;
      a = 16'($urandom); n = 1 + int'($urandom % 10); g = ($urandom % 4) != 0;
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      if (($urandom % 4) != 0) op1(8'h06, 1);
      do_write(a, n, 0, g);
      if (committed) wait_ready;
      rdsr(v, o); check("R6 random status", v, exp_stat());
      check_read("R5 random readback", {6'($urandom), a[9:0] - 10'd2}, 12);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule